// File: doc/BRIEF.md
# Interrupt vector collection controller

This block gathers a wide set of edge-signalled interrupt vectors (by default 128) into latched pending bits. The sources are downstream interrupt producers such as a legacy interrupt controller or message-signalled PCIe interrupts. Every vector has an enable bit beside its pending bit. Software reaches both through a small 32-bit register port. The vectors are packed 32 to a word, and each word drives its own parent interrupt line toward the CPU.

A typical service routine runs as follows. The CPU takes a parent line and reads the pending words to find the active vectors. It acknowledges each vector by writing a one to that vector's pending bit. It masks or unmasks vectors by rewriting the enable words. A vector input may be a one-cycle pulse or a held level; only its rising edge counts as an event.

The asynchronous active-low reset goes through a two-stage synchronizer inside the block before it is released. Register writes take effect at the clock edge that samples them. Read data is registered and appears on the cycle after the read request.

Top module: `irq_vec_collector`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0, all parent lines are low, and read data is 0.
- R2: A rising edge on vector input n sets bit n mod 32 of pending word n/32 at the clock edge that samples it. A level held high sets the bit only once, so after it is cleared the bit stays clear until the next rising edge.
- R3: A pending bit stays set until software writes a 1 to that bit of its pending word (byte offset 4*k for word k). Bits written as 0 are left unchanged, and writing 0xFFFFFFFF clears the whole word.
- R4: A rising edge sets its pending bit even while the vector is masked (enable bit 0). The event is kept, and it raises the parent line once the vector is enabled.
- R5: Parent line k is high exactly while word k holds at least one bit that is both pending and enabled.
- R6: Enable word k sits at byte offset 0x20 + 4*k. A write replaces its contents, a read returns them, and an enable bit of 1 unmasks the vector.
- R7: When a rising edge and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set. The other bits in that write are still cleared.
- R8: A read of an unmapped or misaligned byte offset returns 0. A write to one changes no pending bit, no enable bit and no parent line.
- R9: Read data for a request appears on the cycle after the request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vec_in | input | NUM_WORDS*WORD_W | Vector event inputs, rising-edge detected |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Registered read data |
| parent_irq | output | NUM_WORDS | Parent interrupt lines, one per word |

## Verification
The hardest case to reach from the ports is a collision: a vector's rising edge and a write-one-to-clear of the same bit must land on the same clock edge. The bench forces this by driving the vector input and the write strobe at the same falling edge. That write also clears a second bit that was already pending. The bench then reads the word back to confirm that the colliding bit stayed set and the other bit was cleared. A second case needs care as well: a level held high across an acknowledge. Here the bench keeps the input high while clearing the bit, and confirms that the bit does not come back.

// File: rtl/irqvc_pkg.sv
package irqvc_pkg;

  // Which register bank a decoded offset falls into
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_PEND = 2'd1,
    REG_EN   = 2'd2
  } irqvc_region_e;

  // Byte-offset bits below the word index
  localparam int unsigned IRQVC_BYTE_BITS = 2;

endpackage

// File: rtl/irqvc_word.sv
module irqvc_word #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] vec_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pend_we_i,
  input  logic              en_we_i,
  output logic [WORD_W-1:0] pend_o,
  output logic [WORD_W-1:0] en_o,
  output logic              irq_o
);

  logic [WORD_W-1:0] vec_q;
  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] en_q;
  logic [WORD_W-1:0] edge_w;
  logic [WORD_W-1:0] clr_mask;
  logic [WORD_W-1:0] pend_d;

  // Next-state logic: a new edge always wins over an acknowledge
  always_comb begin
    edge_w   = vec_i & ~vec_q;
    clr_mask = pend_we_i ? wdata_i : '0;
    pend_d   = (pend_q & ~clr_mask) | edge_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      pend_q <= '0;
    end else begin
      vec_q  <= vec_i;
      pend_q <= pend_d;
    end
  end

  // Enable word with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we_i) begin
      en_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_w) |=> ((pend_q & $past(edge_w)) == $past(edge_w)))
    else $error("edge not latched"); // R2

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (&(pend_q | ~$past(pend_q) | $past(clr_mask))))
    else $error("pending bit lost without acknowledge"); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_w & clr_mask)) |=>
      ((pend_q & $past(edge_w & clr_mask)) == $past(edge_w & clr_mask)))
    else $error("acknowledge dropped a coincident edge"); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|edge_w) || en_we_i))
    else $error("parent line rose without edge or enable write"); // R5

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(en_q))
    else $error("enable word changed without write"); // R6

endmodule

// File: rtl/irqvc_decode.sv
module irqvc_decode
  import irqvc_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned EN_BASE   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_WORDS*WORD_W-1:0] pend_i,
  input  logic [NUM_WORDS*WORD_W-1:0] en_i,
  output logic [NUM_WORDS-1:0]        pend_we_o,
  output logic [NUM_WORDS-1:0]        en_we_o,
  output logic [WORD_W-1:0]           rdata_o
);

  localparam int unsigned IDX_W = ADDR_W - IRQVC_BYTE_BITS;
  localparam logic [ADDR_W-1:0] PEND_END = ADDR_W'(NUM_WORDS * 4);
  localparam logic [ADDR_W-1:0] EN_LO    = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI    = ADDR_W'(EN_BASE + NUM_WORDS * 4);

  irqvc_region_e     region;
  logic [ADDR_W-1:0] en_off;
  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;

  // Offset decode: word-aligned hits in either bank, everything else unmapped
  always_comb begin
    region   = REG_NONE;
    en_off   = addr_i - EN_LO;
    word_idx = '0;
    if (addr_i[IRQVC_BYTE_BITS-1:0] == '0) begin
      if (addr_i < PEND_END) begin
        region   = REG_PEND;
        word_idx = addr_i[ADDR_W-1:IRQVC_BYTE_BITS];
      end else if ((addr_i >= EN_LO) && (addr_i < EN_HI)) begin
        region   = REG_EN;
        word_idx = en_off[ADDR_W-1:IRQVC_BYTE_BITS];
      end
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_we
    assign pend_we_o[w] = wr_en_i && (region == REG_PEND) && (word_idx == IDX_W'(w));
    assign en_we_o[w]   = wr_en_i && (region == REG_EN)   && (word_idx == IDX_W'(w));
  end

  // Read mux
  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_idx == IDX_W'(w)) begin
        if (region == REG_PEND) rd_word = pend_i[w*WORD_W +: WORD_W];
        if (region == REG_EN)   rd_word = en_i[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_word;
    end
  end

  assign rdata_o = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (region == REG_NONE)) |=> (rdata_o == '0))
    else $error("unmapped read returned data"); // R8

  AST_UNMAPPED_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (region == REG_NONE) |-> ((pend_we_o == '0) && (en_we_o == '0)))
    else $error("unmapped write reached a bank"); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o))
    else $error("read data changed without request"); // R9

endmodule

// File: rtl/irq_vec_collector.sv
module irq_vec_collector #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned EN_BASE   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS*WORD_W-1:0] vec_in,
  input  logic                        reg_wr_en,
  input  logic                        reg_rd_en,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [WORD_W-1:0]           reg_rdata,
  output logic [NUM_WORDS-1:0]        parent_irq
);

  localparam int unsigned NUM_VEC = NUM_WORDS * WORD_W;

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_VEC-1:0]   pend_all;
  logic [NUM_VEC-1:0]   en_all;
  logic [NUM_WORDS-1:0] pend_we;
  logic [NUM_WORDS-1:0] en_we;

  irqvc_decode #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .EN_BASE   (EN_BASE)
  ) decode_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (reg_wr_en),
    .rd_en_i   (reg_rd_en),
    .addr_i    (reg_addr),
    .pend_i    (pend_all),
    .en_i      (en_all),
    .pend_we_o (pend_we),
    .en_we_o   (en_we),
    .rdata_o   (reg_rdata)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    irqvc_word #(
      .WORD_W (WORD_W)
    ) word_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .vec_i     (vec_in[w*WORD_W +: WORD_W]),
      .wdata_i   (reg_wdata),
      .pend_we_i (pend_we[w]),
      .en_we_i   (en_we[w]),
      .pend_o    (pend_all[w*WORD_W +: WORD_W]),
      .en_o      (en_all[w*WORD_W +: WORD_W]),
      .irq_o     (parent_irq[w])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (parent_irq == '0))
    else $error("parent line high in reset"); // R1

endmodule

// File: tb/irq_vec_collector_tb.sv
module irq_vec_collector_tb_top;

  logic         clk;
  logic         rst_n;
  logic [127:0] vec;
  logic         wr_en;
  logic         rd_en;
  logic [7:0]   addr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [3:0]   parent;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_vec_collector dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_in     (vec),
    .reg_wr_en  (wr_en),
    .reg_rd_en  (rd_en),
    .reg_addr   (addr),
    .reg_wdata  (wdata),
    .reg_rdata  (rdata),
    .parent_irq (parent)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    vec[n] = 1'b1;
    @(negedge clk);
    vec[n] = 1'b0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) begin
      reg_write(8'(4*k), 32'hFFFF_FFFF);
      reg_write(8'(32 + 4*k), 32'h0);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 parent", {28'h0, parent}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    for (int k = 0; k < 4; k++) begin
      reg_read(8'(4*k), d);      check("R1 pending", d, 32'h0);
      reg_read(8'(32 + 4*k), d); check("R1 enable", d, 32'h0);
    end
  endtask

  task automatic t_edge_latch();
    logic [31:0] d;
    pulse(0); pulse(37); pulse(127);
    reg_read(8'h00, d); check("R2 word0", d, 32'h0000_0001);
    reg_read(8'h04, d); check("R2 word1", d, 32'h0000_0020);
    reg_read(8'h08, d); check("R2 word2", d, 32'h0);
    reg_read(8'h0C, d); check("R2 word3", d, 32'h8000_0000);
    reg_write(8'h04, 32'h0);
    reg_read(8'h04, d); check("R3 zero write keeps", d, 32'h0000_0020);
    reg_write(8'h04, 32'h0000_0020);
    reg_read(8'h04, d); check("R3 ack clears", d, 32'h0);
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_read(8'h0C, d); check("R3 full clear", d, 32'h0);
    reg_read(8'h00, d); check("R3 other word kept", d, 32'h0000_0001);
    clear_all();
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); vec[70] = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(8'h08, d); check("R2 level sets", d, 32'h0000_0040);
    reg_write(8'h08, 32'h0000_0040);
    repeat (3) @(negedge clk);
    reg_read(8'h08, d); check("R2 held level no reset", d, 32'h0);
    @(negedge clk); vec[70] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    pulse(10);
    check("R4 masked no parent", {28'h0, parent}, 32'h0);
    reg_read(8'h00, d); check("R4 masked pending", d, 32'h0000_0400);
    reg_write(8'h20, 32'h0000_0400);
    check("R5 parent0 on unmask", {28'h0, parent}, 32'h1);
    reg_write(8'h00, 32'h0000_0400);
    check("R5 parent0 off after ack", {28'h0, parent}, 32'h0);
    clear_all();
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    reg_write(8'h20, 32'hA5A5_0001);
    reg_write(8'h24, 32'h1234_5678);
    reg_write(8'h28, 32'h0);
    reg_write(8'h2C, 32'h0000_0001);
    reg_read(8'h20, d); check("R6 en0", d, 32'hA5A5_0001);
    reg_read(8'h24, d); check("R6 en1", d, 32'h1234_5678);
    reg_read(8'h2C, d); check("R6 en3", d, 32'h0000_0001);
    pulse(96);
    check("R5 parent3 only", {28'h0, parent}, 32'h8);
    pulse(64);
    check("R5 masked word2 stays low", {28'h0, parent}, 32'h8);
    pulse(32 + 3);
    check("R5 parents 1 and 3", {28'h0, parent}, 32'hA);
    clear_all();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(33);
    @(negedge clk);
    vec[50] = 1'b1;
    wr_en = 1'b1; addr = 8'h04; wdata = 32'h0004_0002;
    @(negedge clk);
    wr_en = 1'b0; vec[50] = 1'b0;
    reg_read(8'h04, d); check("R7 set wins", d, 32'h0004_0000);
    clear_all();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    reg_write(8'h24, 32'h0000_00F0);
    pulse(36);
    reg_write(8'h10, 32'hFFFF_FFFF);
    reg_write(8'h1C, 32'hFFFF_FFFF);
    reg_write(8'h30, 32'hFFFF_FFFF);
    reg_write(8'h26, 32'h0);
    reg_write(8'h05, 32'hFFFF_FFFF);
    reg_read(8'h04, d); check("R8 pending untouched", d, 32'h0000_0010);
    reg_read(8'h24, d); check("R8 enable untouched", d, 32'h0000_00F0);
    check("R8 parent untouched", {28'h0, parent}, 32'h2);
    reg_read(8'h10, d); check("R8 read 0x10", d, 32'h0);
    reg_read(8'h04, d);
    reg_read(8'h26, d); check("R8 read misaligned", d, 32'h0);
    reg_read(8'h24, d);
    repeat (3) @(negedge clk);
    check("R9 rdata holds", rdata, 32'h0000_00F0);
    clear_all();
  endtask

  initial begin
    vec = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_edge_latch();
    t_level();
    t_masked();
    t_enable_rw();
    t_collide();
    t_unmapped();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule